// File: doc/BRIEF.md
# Plug-and-Play Card Isolation Unlock and Serial Identifier

This block is the card-side front end of a legacy plug-and-play configuration protocol. The host writes bytes to an address port. The card stays locked until it sees a reset run of zero bytes followed by a 32-byte unlock key. Each key byte comes from an 8-bit linear feedback shift register. Once the key is complete the card enters its configuration state. In that state an address-port write picks a register index, and a write-data-port write stores a value into that register.

In the configuration state the host can:
- give the card a number;
- choose one of several logical devices;
- switch the chosen device on or off;
- store its base address, interrupt line and DMA channel.

All of these values read back through a read-data port. A wake write followed by a start command begins serial identifier readout. The card then returns its 72-bit identifier one bit per pair of reads, as fixed byte patterns.

The unlock detector is an FSM with the states KS_HUNT0, KS_HUNT1, KS_KEY and KS_CONFIG:
- A 0x00 on the address port moves it from KS_HUNT0 to KS_HUNT1, and a second 0x00 moves it to KS_KEY.
- In KS_KEY, a byte that matches the expected key byte advances the key position. The last match moves it to KS_CONFIG.
- In KS_KEY, a 0x00 restarts the key from position 0, and any other mismatch drops the FSM back to KS_HUNT0. A nonzero byte in KS_HUNT1 also drops it to KS_HUNT0.
- An exit command moves it from KS_CONFIG to KS_HUNT0.

The readout sequencer has the states ID_IDLE, ID_FIRST and ID_SECOND:
- A start command moves it from ID_IDLE to ID_FIRST at bit 0.
- A read moves it from ID_FIRST to ID_SECOND.
- A read in ID_SECOND moves it to ID_FIRST of the next bit, or to ID_IDLE after bit 71.
- Any other write-data-port write, or leaving configuration, returns it to ID_IDLE.

Top module: `pnp_iso_card`

## Requirements
- R1: After reset the card is locked (`cfg_mode`=0), `card_num` is 0, every `ldev_active` bit is 0 and `rd_data` is 0.
- R2: Two 0x00 writes to the address port followed by the 32 key bytes unlock the card on the last key byte. The first key byte is 0x6A. Every later byte is the previous byte shifted right by one, with bit 7 set to bit 0 XOR bit 1 of the previous byte. The key ends 0xE7, 0x73, 0x39.
- R3: While locked, a byte that breaks the key does not unlock the card. A 0x00 restarts the key, and any other wrong byte requires two fresh 0x00 writes. Also while locked, write-data-port writes change nothing and `rd_data` is 0.
- R4: In configuration, an address-port write sets the register index, and a write-data-port write stores into the indexed register. Index 0x06 holds `card_num`, which reads back at index 0x06.
- R5: Index 0x07 selects logical device n (read back at 0x07). Writing index 0x30 sets `ldev_active[n]` to bit 0 of the value (1 = on, 0 = off), and index 0x30 reads back that bit.
- R6: For the selected device, index 0x60 holds the base address high byte, 0x61 the low byte, 0x70 the IRQ and 0x74 the DMA channel, and each reads back. Each device keeps its own values. Other indices read 0. A selector at or above NUM_LDEV ignores device writes and reads 0.
- R7: Writing 0x01 to index 0x03 and then 0x80 to index 0x00 starts readout at bit 0. Bit k is bit k%8 of identifier byte k/8, so byte 0 is sent first, least significant bit first. A 1 bit reads 0x55 then 0xAA, and a 0 bit reads 0x00 twice.
- R8: Without the wake write, 0x80 to index 0x00 does not start readout. After bit 71 has been read, or after any other write-data-port write, reads return register readback again.
- R9: Writing 0x02 to index 0x02 leaves configuration. Stored registers are kept, and a new zero run and key are needed to re-enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Write strobe for the address port |
| data_wr | input | 1 | Write strobe for the write-data port |
| rd_req | input | 1 | Read strobe for the read-data port |
| wdata | input | 8 | Write byte for either port |
| rd_data | output | 8 | Read-data port value for a read in this cycle |
| cfg_mode | output | 1 | Card is in the configuration state |
| card_num | output | 8 | Assigned card number |
| ldev_active | output | NUM_LDEV | Activation bit per logical device |

## Verification
The bench runs three wrong-key cases:
- a key with no leading zeros, which a detector that skips the reset run would accept;
- a wrong byte in the middle, which a detector that fails to rewind would accept;
- a zero inside the key, after which a detector that does not restart at 0x6A would lose the key that follows.

For readout, the bench steps through all 144 reads and compares each byte. An off-by-one bit pointer, reversed bit order within a byte, or swapped 0x55/0xAA phases would show up there. The bench also reads past bit 71, to catch a sequencer that wraps around, and interrupts a readout with a write, to catch a sequencer that ignores the write. Finally it checks that device resources stay separate across selectors, that an out-of-range selector is ignored, and that registers survive exit and re-entry.

// File: rtl/pnp_iso_pkg.sv
package pnp_iso_pkg;

    typedef enum logic [1:0] {
        KS_HUNT0,
        KS_HUNT1,
        KS_KEY,
        KS_CONFIG
    } key_state_e;

    typedef enum logic [1:0] {
        ID_IDLE,
        ID_FIRST,
        ID_SECOND
    } id_state_e;

    localparam logic [7:0] IDX_START = 8'h00;
    localparam logic [7:0] IDX_EXIT  = 8'h02;
    localparam logic [7:0] IDX_WAKE  = 8'h03;
    localparam logic [7:0] IDX_CARD  = 8'h06;
    localparam logic [7:0] IDX_LSEL  = 8'h07;
    localparam logic [7:0] IDX_ACT   = 8'h30;
    localparam logic [7:0] IDX_BHI   = 8'h60;
    localparam logic [7:0] IDX_BLO   = 8'h61;
    localparam logic [7:0] IDX_IRQ   = 8'h70;
    localparam logic [7:0] IDX_DMA   = 8'h74;

    // Advance the key generator by one byte.
    function automatic logic [7:0] key_step(input logic [7:0] b);
        return {b[0] ^ b[1], b[7:1]};
    endfunction

endpackage

// File: rtl/pnp_key_fsm.sv
module pnp_key_fsm
    import pnp_iso_pkg::*;
#(
    parameter int         KEY_LEN  = 32,
    parameter logic [7:0] KEY_SEED = 8'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       in_cfg
);
    localparam int            CW   = $clog2(KEY_LEN);
    localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

    key_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [7:0]    exp_q, exp_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        exp_d   = exp_q;
        unique case (state_q)
            KS_HUNT0: begin
                if (addr_wr && wdata == 8'h00) state_d = KS_HUNT1;
            end
            KS_HUNT1: begin
                if (addr_wr) begin
                    if (wdata == 8'h00) begin
                        state_d = KS_KEY;
                        cnt_d   = '0;
                        exp_d   = KEY_SEED;
                    end else begin
                        state_d = KS_HUNT0;
                    end
                end
            end
            KS_KEY: begin
                if (addr_wr) begin
                    if (wdata == exp_q) begin
                        if (cnt_q == LAST) begin
                            state_d = KS_CONFIG;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                            exp_d = key_step(exp_q);
                        end
                    end else if (wdata == 8'h00) begin
                        cnt_d = '0;
                        exp_d = KEY_SEED;
                    end else begin
                        state_d = KS_HUNT0;
                    end
                end
            end
            KS_CONFIG: begin
                if (exit_req) state_d = KS_HUNT0;
            end
            default: state_d = KS_HUNT0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_HUNT0;
            cnt_q   <= '0;
            exp_q   <= KEY_SEED;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            exp_q   <= exp_d;
        end
    end

    always_comb in_cfg = (state_q == KS_CONFIG);

    // R2: configuration is only ever entered on an address-port write.
    assert_cfg_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_cfg) |-> $past(addr_wr));

    // R9: configuration is left only through the exit command.
    assert_cfg_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_cfg) |-> $past(exit_req));

endmodule

// File: rtl/pnp_serial_id.sv
module pnp_serial_id
    import pnp_iso_pkg::*;
#(
    parameter int            ID_BITS   = 72,
    parameter logic [71:0]   SERIAL_ID = 72'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       rd_req,
    output logic       id_run,
    output logic [7:0] id_byte
);
    localparam int            PW   = $clog2(ID_BITS);
    localparam logic [PW-1:0] LAST = PW'(ID_BITS - 1);

    id_state_e     state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic          cur_bit;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (start) begin
            state_d = ID_FIRST;
            ptr_d   = '0;
        end else if (stop) begin
            state_d = ID_IDLE;
        end else if (rd_req) begin
            unique case (state_q)
                ID_IDLE:   ;
                ID_FIRST:  state_d = ID_SECOND;
                ID_SECOND: begin
                    if (ptr_q == LAST) begin
                        state_d = ID_IDLE;
                    end else begin
                        state_d = ID_FIRST;
                        ptr_d   = ptr_q + 1'b1;
                    end
                end
                default:   state_d = ID_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ID_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        cur_bit = SERIAL_ID[ptr_q];
        id_run  = (state_q != ID_IDLE);
        unique case (state_q)
            ID_FIRST:  id_byte = cur_bit ? 8'h55 : 8'h00;
            ID_SECOND: id_byte = cur_bit ? 8'hAA : 8'h00;
            default:   id_byte = 8'h00;
        endcase
    end

    // R7: the bit pointer never leaves the identifier while readout runs.
    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        id_run |-> ptr_q <= LAST);

    // R8: readout ends only after the last bit or on a stop.
    assert_run_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_run) |-> ($past(stop) || $past(ptr_q) == LAST));

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
    import pnp_iso_pkg::*;
#(
    parameter int NUM_LDEV = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_cfg,
    input  logic                addr_wr,
    input  logic                data_wr,
    input  logic [7:0]          wdata,
    output logic                exit_req,
    output logic                id_start,
    output logic [7:0]          card_num,
    output logic [NUM_LDEV-1:0] ldev_active,
    output logic [7:0]          reg_val
);
    localparam int         LW    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam logic [7:0] NUM_B = 8'(NUM_LDEV);

    logic [7:0]          idx_q, card_q, lsel_q;
    logic                wake_q;
    logic [NUM_LDEV-1:0] act_q;
    logic [7:0]          bhi_q [NUM_LDEV];
    logic [7:0]          blo_q [NUM_LDEV];
    logic [7:0]          irq_q [NUM_LDEV];
    logic [7:0]          dma_q [NUM_LDEV];
    logic                wr_ok, sel_ok;
    logic [LW-1:0]       li;

    always_comb begin
        wr_ok    = in_cfg && data_wr;
        sel_ok   = lsel_q < NUM_B;
        li       = lsel_q[LW-1:0];
        exit_req = wr_ok && idx_q == IDX_EXIT && wdata == 8'h02;
        id_start = wr_ok && idx_q == IDX_START && wdata == 8'h80 && wake_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            card_q <= '0;
            lsel_q <= '0;
            wake_q <= 1'b0;
            act_q  <= '0;
            for (int i = 0; i < NUM_LDEV; i++) begin
                bhi_q[i] <= '0;
                blo_q[i] <= '0;
                irq_q[i] <= '0;
                dma_q[i] <= '0;
            end
        end else begin
            if (!in_cfg) wake_q <= 1'b0;
            if (in_cfg && addr_wr) idx_q <= wdata;
            if (wr_ok) begin
                case (idx_q)
                    IDX_WAKE:  wake_q <= (wdata == 8'h01);
                    IDX_START: if (id_start) wake_q <= 1'b0;
                    IDX_EXIT:  if (exit_req) wake_q <= 1'b0;
                    IDX_CARD:  card_q <= wdata;
                    IDX_LSEL:  lsel_q <= wdata;
                    default:   ;
                endcase
                if (sel_ok) begin
                    case (idx_q)
                        IDX_ACT: act_q[li] <= wdata[0];
                        IDX_BHI: bhi_q[li] <= wdata;
                        IDX_BLO: blo_q[li] <= wdata;
                        IDX_IRQ: irq_q[li] <= wdata;
                        IDX_DMA: dma_q[li] <= wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        reg_val = 8'h00;
        case (idx_q)
            IDX_CARD: reg_val = card_q;
            IDX_LSEL: reg_val = lsel_q;
            IDX_ACT:  if (sel_ok) reg_val = {7'b0, act_q[li]};
            IDX_BHI:  if (sel_ok) reg_val = bhi_q[li];
            IDX_BLO:  if (sel_ok) reg_val = blo_q[li];
            IDX_IRQ:  if (sel_ok) reg_val = irq_q[li];
            IDX_DMA:  if (sel_ok) reg_val = dma_q[li];
            default:  reg_val = 8'h00;
        endcase
    end

    assign card_num    = card_q;
    assign ldev_active = act_q;

    // R4: the card number changes only on a write-data-port write.
    assert_card_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(card_num));

    // R5: activation bits change only on a write-data-port write.
    assert_act_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(ldev_active));

endmodule

// File: rtl/pnp_iso_card.sv
module pnp_iso_card
    import pnp_iso_pkg::*;
#(
    parameter int          NUM_LDEV  = 6,
    parameter int          KEY_LEN   = 32,
    parameter int          ID_BITS   = 72,
    parameter logic [71:0] SERIAL_ID = 72'h9E_00_00_00_01_1F_C3_5A_A5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_wr,
    input  logic                data_wr,
    input  logic                rd_req,
    input  logic [7:0]          wdata,
    output logic [7:0]          rd_data,
    output logic                cfg_mode,
    output logic [7:0]          card_num,
    output logic [NUM_LDEV-1:0] ldev_active
);
    logic       in_cfg, exit_req, id_start, id_run;
    logic [7:0] id_byte, reg_val;

    pnp_key_fsm #(.KEY_LEN(KEY_LEN), .KEY_SEED(8'h6A)) u_key (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .wdata(wdata),
        .exit_req(exit_req), .in_cfg(in_cfg)
    );

    pnp_cfg_regs #(.NUM_LDEV(NUM_LDEV)) u_regs (
        .clk(clk), .rst_n(rst_n), .in_cfg(in_cfg), .addr_wr(addr_wr),
        .data_wr(data_wr), .wdata(wdata), .exit_req(exit_req),
        .id_start(id_start), .card_num(card_num),
        .ldev_active(ldev_active), .reg_val(reg_val)
    );

    pnp_serial_id #(.ID_BITS(ID_BITS), .SERIAL_ID(SERIAL_ID)) u_sid (
        .clk(clk), .rst_n(rst_n), .start(id_start),
        .stop(data_wr || !in_cfg), .rd_req(rd_req),
        .id_run(id_run), .id_byte(id_byte)
    );

    always_comb begin
        if (!in_cfg)     rd_data = 8'h00;
        else if (id_run) rd_data = id_byte;
        else             rd_data = reg_val;
    end

    assign cfg_mode = in_cfg;

    // R3: while locked, data-port writes leave the stored state untouched.
    assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && data_wr) |=> ($stable(card_num) && $stable(ldev_active)));

endmodule

// File: tb/pnp_iso_card_tb.sv
`timescale 1ns/1ps
module pnp_iso_card_tb;
    localparam int          NLD = 6;
    localparam logic [71:0] SID = 72'h9E_00_00_00_01_1F_C3_5A_A5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           addr_wr = 1'b0, data_wr = 1'b0, rd_req = 1'b0;
    logic [7:0]     wdata = 8'h00;
    logic [7:0]     rd_data, card_num;
    logic           cfg_mode;
    logic [NLD-1:0] ldev_active;

    always #4 clk = ~clk;

    pnp_iso_card #(.NUM_LDEV(NLD), .SERIAL_ID(SID)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
        .rd_req(rd_req), .wdata(wdata), .rd_data(rd_data),
        .cfg_mode(cfg_mode), .card_num(card_num), .ldev_active(ldev_active)
    );

    int    errs = 0, checks = 0;
    string cur_req = "R1";
    bit    run_on = 1'b0;

    // Behavioural reference state
    int m_ks = 0, m_kpos = 0, m_cfg = 0;
    int m_idx = 0, m_card = 0, m_lsel = 0, m_wake = 0;
    int m_id = 0, m_ptr = 0;
    int m_act [NLD], m_bhi [NLD], m_blo [NLD], m_irq [NLD], m_dma [NLD];

    function automatic int key_byte(int n);
        logic [7:0] b = 8'h6A;
        for (int i = 0; i < n; i++) b = {b[0] ^ b[1], b[7:1]};
        return int'(b);
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_rd();
        int bitv;
        if (m_cfg == 0) return 0;
        if (m_id != 0) begin
            bitv = int'(SID[m_ptr]);
            if (m_id == 1) return bitv ? 'h55 : 0;
            return bitv ? 'hAA : 0;
        end
        case (m_idx)
            'h06: return m_card;
            'h07: return m_lsel;
            'h30: return (m_lsel < NLD) ? m_act[m_lsel] : 0;
            'h60: return (m_lsel < NLD) ? m_bhi[m_lsel] : 0;
            'h61: return (m_lsel < NLD) ? m_blo[m_lsel] : 0;
            'h70: return (m_lsel < NLD) ? m_irq[m_lsel] : 0;
            'h74: return (m_lsel < NLD) ? m_dma[m_lsel] : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model_addr(int b);
        if (m_cfg != 0) begin m_idx = b; return; end
        case (m_ks)
            0: if (b == 0) m_ks = 1;
            1: if (b == 0) begin m_ks = 2; m_kpos = 0; end else m_ks = 0;
            default: begin
                if (b == key_byte(m_kpos)) begin
                    if (m_kpos == 31) m_cfg = 1; else m_kpos++;
                end else if (b == 0) m_kpos = 0;
                else m_ks = 0;
            end
        endcase
    endtask

    task automatic model_data(int b);
        if (m_cfg == 0) return;
        m_id = 0;
        case (m_idx)
            'h00: if (b == 'h80 && m_wake != 0) begin m_id = 1; m_ptr = 0; m_wake = 0; end
            'h02: if (b == 'h02) begin m_cfg = 0; m_ks = 0; m_wake = 0; end
            'h03: m_wake = (b == 1);
            'h06: m_card = b;
            'h07: m_lsel = b;
            default: ;
        endcase
        if (m_lsel < NLD) begin
            case (m_idx)
                'h30: m_act[m_lsel] = b & 1;
                'h60: m_bhi[m_lsel] = b;
                'h61: m_blo[m_lsel] = b;
                'h70: m_irq[m_lsel] = b;
                'h74: m_dma[m_lsel] = b;
                default: ;
            endcase
        end
    endtask

    task automatic model_read();
        if (m_cfg == 0 || m_id == 0) return;
        if (m_id == 1) m_id = 2;
        else if (m_ptr == 71) m_id = 0;
        else begin m_id = 1; m_ptr++; end
    endtask

    function automatic int model_active();
        int v = 0;
        for (int i = 0; i < NLD; i++) v |= (m_act[i] << i);
        return v;
    endfunction

    // Per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (run_on) begin
            chk(cur_req, int'(cfg_mode), m_cfg, "cfg_mode");
            chk(cur_req, int'(card_num), m_card, "card_num");
            chk(cur_req, int'(ldev_active), model_active(), "ldev_active");
        end
    end

    task automatic op_addr(int b);
        @(negedge clk); addr_wr = 1'b1; wdata = 8'(b);
        @(posedge clk); model_addr(b);
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic op_data(int b);
        @(negedge clk); data_wr = 1'b1; wdata = 8'(b);
        @(posedge clk); model_data(b);
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic op_read();
        @(negedge clk); rd_req = 1'b1; #1;
        chk(cur_req, int'(rd_data), model_rd(), "rd_data");
        @(posedge clk); model_read();
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic wreg(int idx, int v);
        op_addr(idx); op_data(v);
    endtask

    task automatic rreg(int idx);
        op_addr(idx); op_read();
    endtask

    task automatic send_key(int upto);
        for (int i = 0; i < upto; i++) op_addr(key_byte(i));
    endtask

    initial begin
        #(8 * 200000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLD; i++) begin
            m_act[i] = 0; m_bhi[i] = 0; m_blo[i] = 0; m_irq[i] = 0; m_dma[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        run_on = 1'b1;
        cur_req = "R1"; op_read();

        // R3: locked behaviour and broken keys
        cur_req = "R3";
        op_data(8'h44); op_read();
        send_key(32);
        op_addr(0); op_addr(0); send_key(10); op_addr(8'h13); send_key(32);
        op_addr(0); op_addr(0); send_key(20); op_addr(0); op_addr(8'h6A); op_addr(8'hB5);
        chk("R3", int'(cfg_mode), 0, "partial key left locked");
        cur_req = "R2";
        op_addr(0); op_addr(0); op_addr(0); send_key(31);
        chk("R2", int'(cfg_mode), 0, "one byte short");
        op_addr(key_byte(31));
        chk("R2", int'(cfg_mode), 1, "unlocked");
        chk("R2", key_byte(31), 'h39, "last key byte");

        cur_req = "R4";
        wreg(8'h06, 8'h02); rreg(8'h06);
        chk("R4", int'(card_num), 2, "card number");

        cur_req = "R5";
        wreg(8'h07, 3); wreg(8'h30, 1); rreg(8'h30); rreg(8'h07);
        wreg(8'h07, 0); wreg(8'h30, 8'h03); wreg(8'h30, 0); wreg(8'h30, 1);

        cur_req = "R6";
        wreg(8'h60, 8'h02); wreg(8'h61, 8'h50); wreg(8'h70, 3); wreg(8'h74, 7);
        wreg(8'h07, 3);
        wreg(8'h60, 8'h02); wreg(8'h61, 8'h20); wreg(8'h70, 5); wreg(8'h74, 1);
        rreg(8'h60); rreg(8'h61); rreg(8'h70); rreg(8'h74);
        wreg(8'h07, 0);
        rreg(8'h60); rreg(8'h61); rreg(8'h70); rreg(8'h74); rreg(8'h55);
        wreg(8'h07, 7); wreg(8'h30, 1); wreg(8'h70, 9); rreg(8'h70); rreg(8'h30);

        cur_req = "R8";
        wreg(8'h06, 8'h02); wreg(8'h00, 8'h80); op_read(); op_read();
        wreg(8'h03, 2); wreg(8'h00, 8'h80); op_read();

        cur_req = "R7";
        wreg(8'h03, 1); wreg(8'h00, 8'h80);
        for (int i = 0; i < 144; i++) op_read();
        cur_req = "R8";
        op_read(); op_read();
        wreg(8'h03, 1); wreg(8'h00, 8'h80);
        for (int i = 0; i < 9; i++) op_read();
        op_data(8'h11); op_read(); op_read();

        cur_req = "R9";
        wreg(8'h02, 2);
        chk("R9", int'(cfg_mode), 0, "left configuration");
        op_read(); op_addr(8'h06); op_data(8'h77);
        op_addr(0); op_addr(0); send_key(32);
        chk("R9", int'(cfg_mode), 1, "re-entered");
        rreg(8'h06); rreg(8'h07); wreg(8'h07, 3); rreg(8'h61);

        run_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule